// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial memory of 1024 bytes. It runs entirely on a fast system clock. It brings the serial clock, the active-low select and the serial input into that domain through flop chains, and it finds serial clock edges by comparing each sample with the one before. Each transaction starts with an 8-bit instruction, sent most significant bit first. The block decodes it. For array access a 16-bit address follows, of which only the low bits are kept.

Array reads fetch bytes from a synchronous RAM port with one cycle of latency. The block streams the bytes out on the falling serial clock edges and wraps over the whole array. Status reads return the three protection bits supplied by a neighbour, or a steady high while a nonvolatile write is busy. Writes, write-enable changes and protection updates are not carried out here. They are passed to the other blocks as single-cycle strobes, and the deselect edge decides whether a command is final.

Top module: `spimem_front`

## Requirements
- R1: After reset nothing is decoded until `spi_cs_n` has been seen going from high to low. A transaction clocked while select was already low at reset produces no strobe and no output.
- R2: `spi_miso_oe` is low whenever `spi_cs_n` is high and during the instruction and address bits. It rises on the first falling serial clock edge that carries read or status data.
- R3: Instruction 06h pulses `wen_set`, and 04h pulses `wen_clr`, on the deselect edge only when exactly 8 bits were clocked. Any other bit count gives no pulse.
- R4: Instruction 03h takes a 16-bit address, most significant bit first, and uses only bits 9:0. Data bytes then appear on `spi_miso` most significant bit first, and each bit changes on a falling serial clock edge. The first bit appears on the falling edge that follows the last address bit.
- R5: While select stays low, a read continues with the next address after every 8 data bits. After address 3FFh it continues at 000h.
- R6: Instruction 05h returns the byte {00000b, `lock_state`[2:0]}, repeated for as long as it is clocked. While `nv_busy` is high, every bit of that byte is 1.
- R7: Instruction 02h takes a 16-bit address like R4. Each completed data byte pulses `wr_req` with `wr_data` and `wr_addr`. The low 4 address bits advance after each byte and wrap inside the 16-byte page, while bits 9:4 stay fixed.
- R8: `wr_commit` pulses on the deselect edge of a write only if at least one data byte was completed and select rose on a byte boundary.
- R9: Instruction 01h followed by one or more whole bytes pulses `lock_req` on a deselect edge that falls on a byte boundary. `lock_val` then carries bits 2:0 of the last byte received.
- R10: Any other instruction byte is ignored until deselect: no strobe, and `spi_miso_oe` stays low.
- R11: Both idle levels of the serial clock (modes 0 and 3) give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, asynchronous to clk |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (low = high impedance) |
| nv_busy | input | 1 | Nonvolatile write in progress |
| lock_state | input | 3 | Current protection setting |
| rd_req | output | 1 | Array read strobe |
| rd_addr | output | 10 | Array read address |
| rd_data | input | 8 | Read data, valid one cycle after rd_req |
| wr_req | output | 1 | One data byte received |
| wr_addr | output | 10 | Address of that byte |
| wr_data | output | 8 | That byte |
| wr_commit | output | 1 | Write sequence closed correctly |
| wen_set | output | 1 | Set write-enable latch |
| wen_clr | output | 1 | Clear write-enable latch |
| lock_req | output | 1 | Protection update request |
| lock_val | output | 3 | New protection setting |

## Verification
Every serial clock edge takes three system cycles to act: two synchronizer flops, then the edge-compare register. A falling edge therefore changes `spi_miso` about four cycles after the pin moves. A read strobe reaches the captured read buffer three cycles after the rising edge that requested it. The bench holds each serial clock level for eight system cycles, so every output has settled before it is sampled. It samples `spi_miso` just before the next rising edge. Strobes are counted on falling `clk` edges by a monitor. Their totals are compared only after the deselect edge has passed through the synchronizer, 200 ns later.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
   localparam int BYTE_W = 8;
   localparam int PROT_W = 3;
   localparam logic [BYTE_W-1:0] OPC_WEN  = 8'h06;
   localparam logic [BYTE_W-1:0] OPC_WDIS = 8'h04;
   localparam logic [BYTE_W-1:0] OPC_LOCK = 8'h01;
   localparam logic [BYTE_W-1:0] OPC_STAT = 8'h05;
   localparam logic [BYTE_W-1:0] OPC_WR   = 8'h02;
   localparam logic [BYTE_W-1:0] OPC_RD   = 8'h03;

   typedef enum logic [2:0] {
      PH_OP, PH_ADDR, PH_RDATA, PH_STAT, PH_WDATA, PH_LOCK, PH_HOLD, PH_IGN
   } phase_t;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spimem_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spimem_wr_ptr.sv
module spimem_wr_ptr #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   generate
      if (PAGE_W >= ADDR_W) begin : g_bad_page
         $error("spimem_wr_ptr: PAGE_W must be below ADDR_W");
      end
      if (PAGE_W > 0) begin : g_paged
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ptr <= '0;
            else if (load) ptr <= load_val;
            else if (step) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
         end
         // R7
         page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !load) |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
      end else begin : g_linear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ptr <= '0;
            else if (load) ptr <= load_val;
            else if (step) ptr <= ptr + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/spimem_front.sv
module spimem_front
   import spimem_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int PAGE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic              nv_busy,
   input  logic [2:0]        lock_state,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_commit,
   output logic              wen_set,
   output logic              wen_clr,
   output logic              lock_req,
   output logic [2:0]        lock_val
);
   localparam int HI_W = ADDR_W - BYTE_W;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("spimem_front: ADDR_W must lie in 9..16");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       csn_s, sck_s, si_s, csn_p, sck_p;
   logic       sck_rise, sck_fall, csn_rise, csn_fall;

   spimem_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({spi_cs_n, spi_sck, spi_mosi}), .q(pins_s));

   assign {csn_s, sck_s, si_s} = pins_s;
   assign sck_rise = sck_s & ~sck_p;
   assign sck_fall = ~sck_s & sck_p;
   assign csn_rise = csn_s & ~csn_p;
   assign csn_fall = ~csn_s & csn_p;

   phase_t            phase;
   logic              armed, sess, out_en, so_q, rd_pend;
   logic [2:0]        bitc, byte_n;
   logic [6:0]        sh;
   logic [7:0]        cmd, rbuf, nb, stat_byte;
   logic [HI_W-1:0]   addr_hi;
   logic [ADDR_W-1:0] full_addr, ra_q, ptr;
   logic              byte_done, ptr_load, ptr_step;

   assign sess      = armed & ~csn_s;
   assign nb        = {sh, si_s};
   assign full_addr = {addr_hi, nb};
   assign stat_byte = {5'b00000, lock_state};
   assign byte_done = sess & sck_rise & (bitc == 3'd7);
   assign ptr_load  = byte_done & (phase == PH_ADDR) & (byte_n != 3'd1) & (cmd == OPC_WR);
   assign ptr_step  = byte_done & (phase == PH_WDATA);

   spimem_wr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_wptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(full_addr),
      .step(ptr_step), .ptr(ptr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p <= 1'b0;  csn_p <= 1'b0;  armed <= 1'b0;
         phase <= PH_OP; bitc <= '0;     byte_n <= '0;
         sh <= '0;       cmd <= '0;      addr_hi <= '0;
         ra_q <= '0;     rbuf <= '0;     rd_pend <= 1'b0;
         out_en <= 1'b0; so_q <= 1'b0;
         rd_req <= 1'b0; rd_addr <= '0;
         wr_req <= 1'b0; wr_addr <= '0;  wr_data <= '0;
         wr_commit <= 1'b0; wen_set <= 1'b0; wen_clr <= 1'b0;
         lock_req <= 1'b0;  lock_val <= '0;
      end else begin
         sck_p <= sck_s;
         csn_p <= csn_s;
         rd_req <= 1'b0; wr_req <= 1'b0; wr_commit <= 1'b0;
         wen_set <= 1'b0; wen_clr <= 1'b0; lock_req <= 1'b0;
         rd_pend <= rd_req;
         if (rd_pend) rbuf <= rd_data;
         if (csn_fall) armed <= 1'b1;

         if (csn_rise && armed && bitc == 3'd0) begin
            case (phase)
               PH_HOLD:  if (byte_n == 3'd1) begin
                            if (cmd == OPC_WEN) wen_set <= 1'b1;
                            else                wen_clr <= 1'b1;
                         end
               PH_WDATA: if (byte_n >= 3'd4) wr_commit <= 1'b1;
               PH_LOCK:  if (byte_n >= 3'd2) lock_req  <= 1'b1;
               default: ;
            endcase
         end

         if (!sess) begin
            phase <= PH_OP; bitc <= '0; byte_n <= '0; out_en <= 1'b0;
         end else begin
            if (sck_rise) begin
               sh   <= nb[6:0];
               bitc <= bitc + 1'b1;
               if (bitc == 3'd7) begin
                  if (byte_n != 3'd7) byte_n <= byte_n + 1'b1;
                  case (phase)
                     PH_OP: begin
                        cmd <= nb;
                        case (nb)
                           OPC_WEN, OPC_WDIS: phase <= PH_HOLD;
                           OPC_RD, OPC_WR:    phase <= PH_ADDR;
                           OPC_STAT:          phase <= PH_STAT;
                           OPC_LOCK:          phase <= PH_LOCK;
                           default:           phase <= PH_IGN;
                        endcase
                     end
                     PH_ADDR: begin
                        if (byte_n == 3'd1) addr_hi <= nb[HI_W-1:0];
                        else if (cmd == OPC_RD) begin
                           phase <= PH_RDATA; ra_q <= full_addr;
                           rd_req <= 1'b1;    rd_addr <= full_addr;
                        end else phase <= PH_WDATA;
                     end
                     PH_RDATA: begin
                        ra_q <= ra_q + 1'b1;
                        rd_req <= 1'b1; rd_addr <= ra_q + 1'b1;
                     end
                     PH_WDATA: begin
                        wr_req <= 1'b1; wr_addr <= ptr; wr_data <= nb;
                     end
                     PH_LOCK: lock_val <= nb[2:0];
                     default: ;
                  endcase
               end
            end
            if (sck_fall && (phase == PH_RDATA || phase == PH_STAT)) begin
               out_en <= 1'b1;
               so_q   <= (phase == PH_STAT) ? (nv_busy | stat_byte[~bitc]) : rbuf[~bitc];
            end
         end
      end
   end

   assign spi_miso    = so_q;
   assign spi_miso_oe = out_en;

   // R2
   hiz_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && csn_p) |-> !spi_miso_oe);
   // R3
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wen_set, wen_clr, wr_commit, lock_req}));
   // R10
   ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IGN) |-> !spi_miso_oe);
   // R1
   unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (phase == PH_OP && !spi_miso_oe && !wr_req && !rd_req));
   // R8
   commit_on_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(csn_s && !csn_p));
endmodule

// File: tb/sim_spimem_front.sv
module sim_spimem_front;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, csn = 1'b0, si = 1'b0;
   logic so, so_oe, nv_busy = 1'b0;
   logic [2:0] lock_state = 3'b101;
   logic rd_req, wr_req, wr_commit, wen_set, wen_clr, lock_req;
   logic [9:0] rd_addr, wr_addr;
   logic [7:0] rd_data, wr_data;
   logic [2:0] lock_val;

   always #5 clk = ~clk;

   spimem_front u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(csn), .spi_mosi(si),
      .spi_miso(so), .spi_miso_oe(so_oe), .nv_busy(nv_busy), .lock_state(lock_state),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
      .wen_set(wen_set), .wen_clr(wen_clr), .lock_req(lock_req), .lock_val(lock_val));

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 5) ^ 8'(a >> 3) ^ 8'h3C;
   endfunction

   logic [7:0] mem [1024];
   initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);
   always_ff @(posedge clk) if (rd_req) rd_data <= mem[rd_addr];

   int n_set = 0, n_clr = 0, n_com = 0, n_lock = 0, n_wr = 0, n_oe = 0;
   logic [9:0] wa [16];
   logic [7:0] wd [16];
   always @(negedge clk) begin
      if (wen_set) n_set++;
      if (wen_clr) n_clr++;
      if (wr_commit) n_com++;
      if (lock_req) n_lock++;
      if (so_oe) n_oe++;
      if (wr_req) begin wa[n_wr % 16] = wr_addr; wd[n_wr % 16] = wr_data; n_wr++; end
   end

   int nchk = 0, nerr = 0;
   bit done = 0;
   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xbit(input logic b, output logic r);
      sck = 1'b0; si = b; #80; r = so; sck = 1'b1; #80;
   endtask
   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
   endtask
   task automatic open_t(input bit m3);
      sck = m3; #100; csn = 1'b0; #100;
   endtask
   task automatic close_t(input bit m3);
      if (!m3) sck = 1'b0;
      #80; csn = 1'b1; #200;
   endtask

   // mode, 16-bit address, byte count
   localparam logic [24:0] RVEC [6] = '{
      {1'b0, 16'h0000, 8'd3}, {1'b0, 16'h0155, 8'd4}, {1'b0, 16'h03FE, 8'd4},
      {1'b1, 16'h0200, 8'd3}, {1'b1, 16'h03FF, 8'd2}, {1'b0, 16'hFC10, 8'd2}};

   initial begin
      #1_000_000;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      end
      $finish;
   end

   initial begin
      logic [7:0] rx;
      logic r;
      #2;
      #60; rst_n = 1'b1; #100;
      check("R1 reset oe", {31'b0, so_oe}, 0);
      // R1: select low since reset, full WREN clocked, then deselect: no strobe
      xbyte(8'h06, rx); sck = 1'b0; #80; csn = 1'b1; #200;
      check("R1 unarmed wren", n_set, 0);
      check("R1 unarmed oe", n_oe, 0);

      // R4 R5 R11: table of reads
      for (int v = 0; v < 6; v++) begin
         bit m3;
         int a, n;
         m3 = RVEC[v][24];
         a = int'(RVEC[v][23:8]) % 1024;
         n = int'(RVEC[v][7:0]);
         open_t(m3);
         xbyte(8'h03, rx); xbyte(RVEC[v][23:16], rx); xbyte(RVEC[v][15:8], rx);
         check("R2 oe low in address", {31'b0, so_oe}, 0);
         for (int k = 0; k < n; k++) begin
            xbyte(8'h00, rx);
            check(m3 ? "R11 R5 read byte" : "R4 R5 read byte", rx, mem[(a + k) % 1024]);
         end
         check("R2 oe during data", {31'b0, so_oe}, 1);
         close_t(m3);
         check("R2 oe after deselect", {31'b0, so_oe}, 0);
      end

      // R6 status
      open_t(0); xbyte(8'h05, rx); xbyte(8'h00, rx);
      check("R6 status", rx, 8'h05);
      xbyte(8'h00, rx);
      check("R6 status repeat", rx, 8'h05);
      close_t(0);
      nv_busy = 1'b1;
      open_t(1); xbyte(8'h05, rx); xbyte(8'h00, rx);
      check("R6 busy status", rx, 8'hFF);
      close_t(1);
      nv_busy = 1'b0;

      // R3 enable latch strobes
      open_t(0); xbyte(8'h06, rx); close_t(0);
      check("R3 wren", n_set, 1);
      open_t(1); xbyte(8'h04, rx); close_t(1);
      check("R3 wrdi", n_clr, 1);
      open_t(0); xbyte(8'h06, rx); xbit(1'b0, r); close_t(0);
      check("R3 wren nine bits", n_set, 1);

      // R7 R8 page write with wrap
      open_t(0);
      xbyte(8'h02, rx); xbyte(8'h00, rx); xbyte(8'h1E, rx);
      xbyte(8'hA1, rx); xbyte(8'hB2, rx); xbyte(8'hC3, rx);
      close_t(0);
      check("R7 wr count", n_wr, 3);
      check("R7 wr addr0", wa[0], 10'h01E); check("R7 wr data0", wd[0], 8'hA1);
      check("R7 wr addr1", wa[1], 10'h01F);
      check("R7 wr addr2 wrap", wa[2], 10'h010); check("R7 wr data2", wd[2], 8'hC3);
      check("R8 commit", n_com, 1);
      open_t(1);
      xbyte(8'h02, rx); xbyte(8'h00, rx); xbyte(8'h40, rx); xbyte(8'h55, rx);
      xbit(1'b1, r); xbit(1'b0, r); xbit(1'b1, r);
      close_t(1);
      check("R8 misaligned no commit", n_com, 1);
      check("R7 byte before abort", wa[3], 10'h040);
      open_t(0); xbyte(8'h02, rx); xbyte(8'h00, rx); xbyte(8'h40, rx); close_t(0);
      check("R8 no data no commit", n_com, 1);

      // R9 protection
      open_t(0); xbyte(8'h01, rx); xbyte(8'h06, rx); close_t(0);
      check("R9 lock req", n_lock, 1); check("R9 lock val", lock_val, 3'd6);
      open_t(1); xbyte(8'h01, rx); xbyte(8'h03, rx); xbyte(8'h02, rx); close_t(1);
      check("R9 lock last byte", lock_val, 3'd2); check("R9 lock req2", n_lock, 2);
      open_t(0); xbyte(8'h01, rx); close_t(0);
      check("R9 opcode only", n_lock, 2);

      // R10 unknown opcode
      n_oe = 0;
      open_t(0); xbyte(8'hA5, rx); xbyte(8'h00, rx); xbyte(8'h00, rx); close_t(0);
      check("R10 oe stays low", n_oe, 0);
      check("R10 no strobes", n_set + n_clr + n_com + n_lock, 1 + 1 + 1 + 2);
      check("R10 no write", n_wr, 4);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule